// File: doc/BRIEF.md
# Two-Channel Serial Audio Receiver

This block receives a two-channel serial audio stream from an external master and turns it into parallel sample pairs. The bit clock, word-select clock and serial data all arrive from outside; the block only listens and never drives any of them. The three lines pass through two-flop synchronizers into the master-clock domain. Data and word select are then taken at each detected bit-clock rising edge.

The receiver counts bit clocks between word-select rising edges and accepts any frame of 32 to 64 bit clocks. It locks once two consecutive frames have the same length. While locked it emits one left/right pair per frame, each left-aligned into a 24-bit word. It also times the raw word-select period in master-clock cycles. When that period moves away from the value captured at lock by more than a set number of cycles, it forces a resynchronization and locks again from the start.

A parameter selects the slot layout. In left-justified mode the left channel runs while word select is high and its MSB comes on the first bit clock of the half-frame. In I2S mode the left channel runs while word select is low and each word starts one bit clock after the word-select transition.

Top module: `audrx_rx`

## Requirements
- R1: While `rst_ni` is low, and on the cycle it is released, `valid_o`, `lock_o`, `len_err_o` and `resync_o` are low and `left_o`/`right_o` are zero.
- R2: In left-justified mode, bits taken on bit-clock rising edges while word select is high form the left word, MSB first. Bits taken while it is low form the right word. In 64-clock frames (32-bit slots) the first 24 slot bits fill bits 23..0 and the other 8 are discarded.
- R3: In 32-clock frames (16-bit slots) the 16 slot bits fill bits 23..8 of each output word and bits 7..0 are zero.
- R4: In 48-clock frames (24-bit slots) all 24 slot bits fill bits 23..0 of each output word.
- R5: After reset, a first frame length is measured at the second word-select rising edge. `lock_o` rises at the next rising edge whose measured length equals it. On that same cycle the first pair is emitted, which is the frame that has just ended. After that, each frame's pair is emitted at the word-select rising edge that ends it, with `valid_o` high and `lock_o` high.
- R6: A measured frame of fewer than 32 or more than 64 bit clocks gives a one-cycle `len_err_o` pulse with `lock_o` low. That frame and the following frame are not emitted. Lock returns at the next two equal-length frames.
- R7: While locked, the receiver compares each raw word-select rising-edge period with the period captured just after lock. A difference of more than `DRIFT_MAX` (default 4) master-clock cycles gives a one-cycle `resync_o` pulse with `lock_o` low. The frame that ends at the next word-select rising edge is not emitted, and lock returns one frame later.
- R8: A word-select period difference of at most `DRIFT_MAX` master-clock cycles, with an unchanged bit-clock count, causes no `resync_o` pulse and no lost sample.
- R9: `valid_o` is high for exactly one cycle per pair. `left_o`/`right_o` hold their last emitted value until the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Serial bit clock from the external master |
| ws_i | input | 1 | Word-select (frame) clock from the external master |
| sd_i | input | 1 | Serial audio data |
| left_o | output | SAMPLE_W | Left sample, left-aligned |
| right_o | output | SAMPLE_W | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe: a new pair is on left_o/right_o |
| lock_o | output | 1 | Frame length is stable and the pair stream is running |
| len_err_o | output | 1 | One-cycle pulse: frame length out of range |
| resync_o | output | 1 | One-cycle pulse: word-select drift forced reacquisition |

## Verification
A single malformed frame fires two checks at the same frame boundary. Its bit-clock count falls outside 32..64, and its word-select period also misses the locked reference by far more than the drift limit. Both can try to change the lock and length state in the same cycle, and the resync override must win. The bench provokes this with a 20-clock frame and a 70-clock frame in the middle of a locked stream. It then requires exactly one length-error pulse and one resync pulse, lock low on both pulse cycles, the loss of exactly the malformed frame and the one after it, and bit-exact pairs once lock returns. Separate runs shift one word-select edge by 3 and by 6 master-clock cycles without changing the bit count, to show where the drift threshold lies.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    // Slot layout of the incoming serial stream
    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,  // left while word select high, MSB on first bit
        FMT_I2S       = 1'b1   // left while word select low, MSB one bit late
    } audrx_fmt_e;

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic [1:0] stg_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) stg_q <= '0;
            else         stg_q <= {stg_q[0], d_i[gi]};
        end
        assign q_o[gi] = stg_q[1];
    end

endmodule

// File: rtl/audrx_frame.sv
module audrx_frame #(
    parameter int MIN_BITS  = 32,
    parameter int MAX_BITS  = 64,
    parameter int DRIFT_MAX = 4,
    parameter int PERIOD_W  = 16,
    parameter int CNT_W     = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,     // bit-clock rising edge seen this cycle
    input  logic start_i,    // left channel begins on this bit
    input  logic ws_edge_i,  // raw word-select rising edge, master-clock timed
    output logic lock_o,
    output logic len_err_o,
    output logic resync_o,
    output logic emit_o      // combinational: pair to be captured this cycle
);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    last_len;
        logic                have_ref;
        logic                len_ok;
        logic                lock;
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] pref;
        logic                pref_ok;
        logic                err;
        logic                resync;
    } frm_t;

    frm_t                st_q, st_d;
    logic [PERIOD_W-1:0] drift;

    always_comb begin
        st_d        = st_q;
        st_d.err    = 1'b0;
        st_d.resync = 1'b0;
        drift = (st_q.period > st_q.pref) ? st_q.period - st_q.pref
                                          : st_q.pref - st_q.period;

        // bit-clock count per frame, length check and lock
        if (start_i) begin
            if (st_q.have_ref) begin
                if (st_q.cnt < CNT_W'(MIN_BITS) || st_q.cnt > CNT_W'(MAX_BITS)) begin
                    st_d.err    = 1'b1;
                    st_d.lock   = 1'b0;
                    st_d.len_ok = 1'b0;
                end else begin
                    st_d.lock     = st_q.len_ok && (st_q.cnt == st_q.last_len);
                    st_d.last_len = st_q.cnt;
                    st_d.len_ok   = 1'b1;
                end
            end
            st_d.have_ref = 1'b1;
            st_d.cnt      = CNT_W'(1);
        end else if (rise_i && st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        // word-select period in master-clock cycles, drift watch
        if (st_q.period != '1) st_d.period = st_q.period + 1'b1;
        if (ws_edge_i) begin
            st_d.period = PERIOD_W'(1);
            if (!st_q.lock) begin
                st_d.pref_ok = 1'b0;
            end else if (!st_q.pref_ok) begin
                st_d.pref    = st_q.period;
                st_d.pref_ok = 1'b1;
            end else if (drift > PERIOD_W'(DRIFT_MAX)) begin
                st_d.resync  = 1'b1;
                st_d.lock    = 1'b0;
                st_d.len_ok  = 1'b0;
                st_d.pref_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lock_o    = st_q.lock;
    assign len_err_o = st_q.err;
    assign resync_o  = st_q.resync;
    assign emit_o    = start_i && st_d.lock;

endmodule

// File: rtl/audrx_deser.sv
module audrx_deser #(
    parameter int SAMPLE_W = 24,
    parameter int POS_W    = 7
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rise_i,  // bit-clock rising edge
    input  logic                chg_i,   // channel changed on this bit
    input  logic                chan_i,  // 1: left, 0: right
    input  logic                sd_i,
    input  logic                emit_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] left_sh;
        logic [SAMPLE_W-1:0] right_sh;
        logic [POS_W-1:0]    pos;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                valid;
    } des_t;

    des_t                st_q, st_d;
    logic [POS_W-1:0]    pos_nx;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;

        if (emit_i) begin
            st_d.out_l = st_q.left_sh;
            st_d.out_r = st_q.right_sh;
            st_d.valid = 1'b1;
        end

        pos_nx = chg_i ? '0 : ((st_q.pos == '1) ? st_q.pos : st_q.pos + 1'b1);
        word   = chg_i ? '0 : (chan_i ? st_q.left_sh : st_q.right_sh);
        for (int b = 0; b < SAMPLE_W; b++) begin
            if (pos_nx == POS_W'(SAMPLE_W - 1 - b)) word[b] = sd_i;
        end

        if (rise_i) begin
            st_d.pos = pos_nx;
            if (chan_i) st_d.left_sh  = word;
            else        st_d.right_sh = word;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/audrx_rx.sv
module audrx_rx
    import audrx_pkg::*;
#(
    parameter int         SAMPLE_W  = 24,
    parameter int         MIN_BITS  = 32,
    parameter int         MAX_BITS  = 64,
    parameter int         DRIFT_MAX = 4,
    parameter int         PERIOD_W  = 16,
    parameter audrx_fmt_e FMT       = FMT_LEFT_JUST
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bck_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                lock_o,
    output logic                len_err_o,
    output logic                resync_o
);

    localparam int CNT_W = $clog2(MAX_BITS) + 2;
    localparam int POS_W = $clog2(MAX_BITS) + 1;

    typedef struct packed {
        logic bck_prev;
        logic ws_prev;
        logic ws_bit;   // word select taken at the last bit-clock rise
        logic ews;      // channel of the last bit, 1 = left
    } front_t;

    logic [2:0] syn;
    logic       bck_s, ws_s, sd_s;
    front_t     fr_q, fr_d;
    logic       rise, ews_now, start, chg, ws_edge, emit;

    audrx_sync #(.W(3)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({sd_i, ws_i, bck_i}),
        .q_o   (syn)
    );

    assign bck_s   = syn[0];
    assign ws_s    = syn[1];
    assign sd_s    = syn[2];
    assign rise    = bck_s && !fr_q.bck_prev;
    assign ews_now = (FMT == FMT_I2S) ? !fr_q.ws_bit : ws_s;
    assign chg     = rise && (ews_now != fr_q.ews);
    assign start   = chg && ews_now;
    assign ws_edge = ws_s && !fr_q.ws_prev;

    always_comb begin
        fr_d          = fr_q;
        fr_d.bck_prev = bck_s;
        fr_d.ws_prev  = ws_s;
        if (rise) begin
            fr_d.ws_bit = ws_s;
            fr_d.ews    = ews_now;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) fr_q <= '0;
        else         fr_q <= fr_d;
    end

    audrx_frame #(
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .DRIFT_MAX(DRIFT_MAX),
        .PERIOD_W (PERIOD_W),
        .CNT_W    (CNT_W)
    ) u_frame (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise),
        .start_i  (start),
        .ws_edge_i(ws_edge),
        .lock_o   (lock_o),
        .len_err_o(len_err_o),
        .resync_o (resync_o),
        .emit_o   (emit)
    );

    audrx_deser #(
        .SAMPLE_W(SAMPLE_W),
        .POS_W   (POS_W)
    ) u_deser (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (rise),
        .chg_i  (chg),
        .chan_i (ews_now),
        .sd_i   (sd_s),
        .emit_i (emit),
        .left_o (left_o),
        .right_o(right_o),
        .valid_o(valid_o)
    );

endmodule

// File: rtl/audrx_rx_chk.sv
module audrx_rx_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                valid_o,
    input logic                lock_o,
    input logic                len_err_o,
    input logic                resync_o,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o
);

    assert_valid_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> lock_o)
        else $error("pair emitted without lock");

    assert_lock_emits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> valid_o)
        else $error("lock gained without emitting the pair");

    assert_err_unlock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        len_err_o |-> !lock_o)
        else $error("length error while still locked");

    assert_resync_unlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_o |-> !lock_o)
        else $error("resync while still locked");

    assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o)
        else $error("valid strobe longer than one cycle");

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o)))
        else $error("sample outputs changed without strobe");

endmodule

bind audrx_rx audrx_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_o  (valid_o),
    .lock_o   (lock_o),
    .len_err_o(len_err_o),
    .resync_o (resync_o),
    .left_o   (left_o),
    .right_o  (right_o)
);

// File: tb/audrx_rx_test.sv
module audrx_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int BCK_HALF   = 8;   // master-clock cycles per bit-clock half period
    localparam int SW         = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [SW-1:0] left_o, right_o;
    logic          valid_o, lock_o, len_err_o, resync_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audrx_rx uut (
        .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
        .lock_o(lock_o), .len_err_o(len_err_o), .resync_o(resync_o)
    );

    logic [2*SW-1:0] exp_q[$];
    logic [2*SW-1:0] last_pair = '0;
    string cur_req = "R2";
    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int err_seen = 0, rs_seen = 0;
    logic prev_valid = 1'b0;

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_valid = 1'b0;
        end else begin
            if (len_err_o) err_seen++;
            if (resync_o) rs_seen++;
            if (valid_o) begin
                logic [2*SW-1:0] pair;
                mon_checks++;
                if (prev_valid) begin
                    mon_errors++;
                    $display("FAIL R9 strobe width: actual 2 cycles expected 1");
                end
                if (exp_q.size() == 0) begin
                    mon_errors++;
                    $display("FAIL %s unexpected pair: actual %h expected none", cur_req, {left_o, right_o});
                end else begin
                    pair = exp_q.pop_front();
                    last_pair = pair;
                    if ({left_o, right_o} !== pair) begin
                        mon_errors++;
                        $display("FAIL %s pair: actual %h expected %h", cur_req, {left_o, right_o}, pair);
                    end
                end
            end
            prev_valid = valid_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] expect_word(input logic [31:0] slot, input int half);
        logic [SW-1:0] w = slot[31:8];
        if (half < SW) w &= ({SW{1'b1}} << (SW - half));
        return w;
    endfunction

    // driver: one frame, left-justified; ws rise optionally delayed by lag cycles
    task automatic send_frame(input int bits, input logic [31:0] ls, input logic [31:0] rs,
                              input bit want, input int lag);
        int half = bits / 2;
        if (want) exp_q.push_back({expect_word(ls, half), expect_word(rs, half)});
        for (int i = 0; i < bits; i++) begin
            int j = (i < half) ? i : i - half;
            logic [31:0] slot = (i < half) ? ls : rs;
            bck = 1'b0;
            sd  = (j < 32) ? slot[31-j] : 1'b0;
            if (i == 0 && lag > 0) begin
                repeat (lag) @(negedge clk);
                ws = 1'b1;
                repeat (BCK_HALF - lag) @(negedge clk);
            end else begin
                ws = (i < half);
                repeat (BCK_HALF) @(negedge clk);
            end
            bck = 1'b1;
            repeat (BCK_HALF) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bck = 1'b0; ws = 1'b0; sd = 1'b0;
        repeat (4) @(negedge clk);
        check(!valid_o && !lock_o && !len_err_o && !resync_o, "R1", "flags in reset",
              {valid_o, lock_o, len_err_o, resync_o}, 0);
        check({left_o, right_o} == '0, "R1", "samples in reset", {left_o, right_o}, 0);
        exp_q.delete();
        last_pair = '0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_clean(input int bits, input string req);
        int e0, r0;
        cur_req = req;
        do_reset();
        e0 = err_seen; r0 = rs_seen;
        for (int i = 0; i < 8; i++) begin
            send_frame(bits, $urandom, $urandom, (i >= 1 && i <= 6), 0);
            if (i == 1) check(lock_o == 1'b0, "R5", "no lock after one measured frame", lock_o, 0);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "pairs missing", exp_q.size(), 0);
        check(lock_o == 1'b1, "R5", "lock held", lock_o, 1);
        check(err_seen == e0, "R6", "no length error", err_seen - e0, 0);
        check(rs_seen == r0, "R7", "no resync", rs_seen - r0, 0);
        check({left_o, right_o} == last_pair, "R9", "outputs held", {left_o, right_o}, last_pair);
    endtask

    task automatic run_fault(input int bad_bits, input int lag, input logic [9:0] want,
                             input int n_err, input int n_rs, input string req);
        int e0, r0;
        cur_req = req;
        do_reset();
        e0 = err_seen; r0 = rs_seen;
        for (int i = 0; i < 10; i++) begin
            send_frame((i == 5) ? bad_bits : 64, $urandom, $urandom, want[i], (i == 5) ? lag : 0);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "pairs missing", exp_q.size(), 0);
        check(err_seen - e0 == n_err, "R6", "length error pulses", err_seen - e0, n_err);
        check(rs_seen - r0 == n_rs, "R7", "resync pulses", rs_seen - r0, n_rs);
        check(lock_o == 1'b1, req, "lock regained", lock_o, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    initial begin
        run_clean(64, "R2");                          // 32-bit slots, low 8 dropped
        run_clean(32, "R3");                          // 16-bit slots, zero fill
        run_clean(48, "R4");                          // 24-bit slots
        run_fault(20, 0, 10'h19E, 1, 1, "R6");        // short frame
        run_fault(70, 0, 10'h19E, 1, 1, "R6");        // long frame
        run_fault(64, 6, 10'h1EE, 0, 1, "R7");        // drift beyond limit
        run_fault(64, 3, 10'h1FE, 0, 0, "R8");        // drift within limit
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule